// File: doc/BRIEF.md
# Link Flow Controller

This block sits on the sending end of one point-to-point link and decides, cycle by cycle, whether the sender may put a flit on the wire. The flit goes to a receive buffer of fixed depth at the far end. It supports two back-pressure schemes, chosen by a mode pin. In credit mode it keeps a count of free far-end slots. Each send spends one slot, and each freed-slot pulse that comes back over the link restores one. In stop/go mode it follows a single level that the far end raises as its buffer fills. That level needs no counter, but some buffer space goes unused.

The far-end half is included as a small companion. It tracks buffer occupancy from arrival and free pulses and produces the stop level with hysteresis. The level rises early enough that flits already in flight during one round trip still fit in the buffer. Both the freed-slot pulses and the stop level reach the sender through a return pipeline of 1 to 3 register stages.

The sender side is a valid/ready stream. A flit is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` may fall at any time without warning. The link side has no ready, because space has already been granted by the time a flit is sent. `out_valid` is therefore the send strobe. The mode is held steady between resets.

Top module: `link_flow_ctrl`

## Requirements
- R1: After reset, `credits` equals DEPTH (default 8), and `credit_err`, `off_level` and `stop_seen` are all 0.
- R2: With `mode`=0 (credit scheme), `in_ready` is 1 exactly when `credits` is non-zero, and `out_valid` equals `in_valid & in_ready`.
- R3: In credit mode, a send with no return in the same cycle lowers `credits` by one at the next clock edge.
- R4: A `dn_free` pulse becomes a credit return LAT cycles later (default LAT=2). In credit mode a return raises `credits` by one, and a return together with a send leaves `credits` unchanged.
- R5: A return that arrives when `credits` equals DEPTH and there is no send sets `credit_err`. `credit_err` then stays at 1 until reset, and `credits` stays at DEPTH.
- R6: The far-end occupancy rises by one on `dn_arrive` and falls by one on `dn_free`. It is held within 0..DEPTH, and both pulses in one cycle leave it unchanged.
- R7: `off_level` becomes 1 once occupancy reaches HI = DEPTH − 2·LAT (default 4). It becomes 0 once occupancy is below LO_MARK (default 2). Otherwise it keeps its value. It is registered together with the occupancy.
- R8: With `mode`=1 (stop/go scheme), `stop_seen` is `off_level` delayed by LAT cycles, `in_ready` equals `!stop_seen`, and `credits` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = credit scheme, 1 = stop/go scheme |
| in_valid | input | 1 | Sender has a flit |
| in_ready | output | 1 | Flit may be taken this cycle |
| out_valid | output | 1 | Flit is sent on the link this cycle |
| dn_arrive | input | 1 | Far end: flit written into buffer |
| dn_free | input | 1 | Far end: buffer slot freed |
| credits | output | $clog2(DEPTH+1) | Free far-end slots as seen by sender |
| credit_err | output | 1 | Sticky flag: return beyond DEPTH |
| off_level | output | 1 | Far-end stop level before the return pipeline |
| stop_seen | output | 1 | Stop level as seen by the sender |

## Verification
A send and a credit return can fall in the same cycle. The pair that matters most is a send together with a return while `credits` sits at DEPTH: this must leave the count unchanged and must not set the error flag. The bench drives `in_valid` and `dn_free` at random with independent rates, so both cases come up often. A directed case also sends a `dn_free` pulse exactly LAT cycles before a send from a full count. Each cycle, the expected count and flag come from a bench model of the return pipeline and are compared with the ports.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic {
    SCHEME_CREDIT = 1'b0,
    SCHEME_STOPGO = 1'b1
  } scheme_e;
endpackage

// File: rtl/lfc_delay.sv
module lfc_delay #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int WW = $clog2(LAT + 1);
  logic [LAT-1:0] stage;
  logic [WW-1:0]  warm;

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= d;
  end

  generate
    for (genvar i = 1; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= 1'b0;
        else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                 warm <= '0;
    else if (warm != WW'(LAT))  warm <= warm + 1'b1;
  end

  // R4
  delay_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == WW'(LAT)) |-> (q == $past(d, LAT)));
endmodule

// File: rtl/lfc_credit_ctr.sv
module lfc_credit_ctr #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          send,
  input  logic          ret,
  output logic [CW-1:0] count,
  output logic          err
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic do_send, do_ret;

  assign do_send = enable & send;
  assign do_ret  = enable & ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= FULL;
      err   <= 1'b0;
    end else if (do_send && !do_ret) begin
      count <= count - 1'b1;
    end else if (do_ret && !do_send) begin
      if (count == FULL) err   <= 1'b1;
      else               count <= count + 1'b1;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R4
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_send && do_ret) |=> $stable(count));
endmodule

// File: rtl/lfc_stop_mon.sv
module lfc_stop_mon #(
  parameter int DEPTH   = 8,
  parameter int HI      = 4,
  parameter int LO_MARK = 2,
  parameter int OW      = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic freed,
  output logic off
);
  logic [OW-1:0] occ, occ_nxt;
  logic          off_nxt;

  always_comb begin
    occ_nxt = occ;
    if (arrive && !freed && occ != OW'(DEPTH)) occ_nxt = occ + 1'b1;
    if (freed && !arrive && occ != '0)         occ_nxt = occ - 1'b1;
    if (occ_nxt >= OW'(HI))                    off_nxt = 1'b1;
    else if (occ_nxt < OW'(LO_MARK))           off_nxt = 1'b0;
    else                                       off_nxt = off;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      off <= 1'b0;
    end else begin
      occ <= occ_nxt;
      off <= off_nxt;
    end
  end

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  // R7
  off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= OW'(HI)) |-> off);
  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < OW'(LO_MARK)) |-> !off);
endmodule

// File: rtl/link_flow_ctrl.sv
module link_flow_ctrl #(
  parameter int DEPTH   = 8,
  parameter int LAT     = 2,
  parameter int LO_MARK = 2,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          dn_arrive,
  input  logic          dn_free,
  output logic [CW-1:0] credits,
  output logic          credit_err,
  output logic          off_level,
  output logic          stop_seen
);
  import lfc_pkg::*;
  localparam int HI = DEPTH - 2 * LAT;

  scheme_e scheme;
  logic    ret_pulse, credit_mode;

  assign scheme      = scheme_e'(mode);
  assign credit_mode = (scheme == SCHEME_CREDIT);

  lfc_delay #(.LAT(LAT)) u_ret_dly (
    .clk(clk), .rst_n(rst_n), .d(dn_free), .q(ret_pulse));

  lfc_delay #(.LAT(LAT)) u_stop_dly (
    .clk(clk), .rst_n(rst_n), .d(off_level), .q(stop_seen));

  lfc_stop_mon #(.DEPTH(DEPTH), .HI(HI), .LO_MARK(LO_MARK)) u_mon (
    .clk(clk), .rst_n(rst_n), .arrive(dn_arrive), .freed(dn_free),
    .off(off_level));

  assign in_ready  = credit_mode ? (credits != '0) : !stop_seen;
  assign out_valid = in_valid & in_ready;

  lfc_credit_ctr #(.DEPTH(DEPTH), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .enable(credit_mode), .send(out_valid),
    .ret(ret_pulse), .count(credits), .err(credit_err));

  // R3
  send_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_mode && out_valid && !ret_pulse) |=> (credits == $past(credits) - 1'b1));
  // R8
  stopgo_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!credit_mode && $past(!credit_mode)) |-> $stable(credits));
  // R2
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_mode && credits == '0) |-> !out_valid);
endmodule

// File: tb/link_flow_ctrl_test.sv
`timescale 1ns/1ps
module link_flow_ctrl_test;
  localparam int DEPTH = 8;
  localparam int LAT   = 2;
  localparam int LO    = 2;
  localparam int HI    = DEPTH - 2 * LAT;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, in_valid = 1'b0, dn_arrive = 1'b0, dn_free = 1'b0;
  logic in_ready, out_valid, credit_err, off_level, stop_seen;
  logic [CW-1:0] credits;

  int total = 0, bad = 0;
  int m_cnt, m_occ;
  bit m_err, m_off;
  bit fpipe[LAT];
  bit opipe[LAT];

  always #2.5 clk = ~clk;

  link_flow_ctrl #(.DEPTH(DEPTH), .LAT(LAT), .LO_MARK(LO)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .dn_arrive(dn_arrive),
    .dn_free(dn_free), .credits(credits), .credit_err(credit_err),
    .off_level(off_level), .stop_seen(stop_seen));

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ready();
    if (mode == 1'b0) return (m_cnt != 0) ? 1 : 0;
    return opipe[LAT-1] ? 0 : 1;
  endfunction

  task automatic model_reset();
    m_cnt = DEPTH; m_occ = 0; m_err = 0; m_off = 0;
    for (int i = 0; i < LAT; i++) begin fpipe[i] = 0; opipe[i] = 0; end
  endtask

  task automatic do_reset(input bit md);
    @(negedge clk);
    rst_n = 1'b0; mode = md; in_valid = 0; dn_arrive = 0; dn_free = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #0.5;
    chk(credits, DEPTH, "R1 credits");
    chk(credit_err, 0, "R1 err");
    chk(off_level, 0, "R1 off");
    chk(stop_seen, 0, "R1 stop");
  endtask

  // one cycle: inputs already driven after negedge
  task automatic step();
    int rdy, snd, ret, occ_n;
    #0.5;
    rdy = exp_ready();
    snd = in_valid & rdy;
    ret = fpipe[LAT-1];
    chk(in_ready, rdy, mode ? "R8 ready" : "R2 ready");
    chk(out_valid, snd, "R2 out_valid");
    chk(credits, m_cnt, "R3/R4 credits");
    chk(credit_err, m_err, "R5 err");
    chk(off_level, m_off, "R7 off");
    chk(stop_seen, opipe[LAT-1], "R8 stop");
    if (mode == 1'b0) begin
      if (snd && !ret) m_cnt--;
      else if (ret && !snd) begin
        if (m_cnt == DEPTH) m_err = 1; else m_cnt++;
      end
    end
    occ_n = m_occ;
    if (dn_arrive && !dn_free && m_occ < DEPTH) occ_n++;
    if (dn_free && !dn_arrive && m_occ > 0) occ_n--;
    m_occ = occ_n;
    for (int i = LAT - 1; i > 0; i--) begin fpipe[i] = fpipe[i-1]; opipe[i] = opipe[i-1]; end
    fpipe[0] = dn_free;
    opipe[0] = m_off;
    if (occ_n >= HI) m_off = 1; else if (occ_n < LO) m_off = 0;
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit a, input bit f);
    in_valid = v; dn_arrive = a; dn_free = f;
    step();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R5 directed: return at full count with no send
    do_reset(1'b0);
    drive(0, 0, 1);
    for (int i = 0; i < LAT + 1; i++) drive(0, 0, 0);
    chk(credit_err, 1, "R5 directed err");
    chk(credits, DEPTH, "R5 directed count");
    // R4 directed: return coincides with send at full count
    do_reset(1'b0);
    drive(0, 0, 1);
    for (int i = 0; i < LAT - 1; i++) drive(0, 0, 0);
    drive(1, 0, 0);
    drive(0, 0, 0);
    chk(credits, DEPTH, "R4 pair count");
    chk(credit_err, 0, "R4 pair no err");
    // R2 directed: drain all credits, then blocked
    do_reset(1'b0);
    for (int i = 0; i < DEPTH + 2; i++) drive(1, 0, 0);
    chk(credits, 0, "R2 drained");
    chk(in_ready, 0, "R2 blocked");
    // credit-mode random
    do_reset(1'b0);
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 100) < 55, ($urandom % 100) < 40, ($urandom % 100) < 35);
    // stop/go mode: fill to trip, then drain
    do_reset(1'b1);
    for (int i = 0; i < HI; i++) drive(1, 1, 0);
    chk(off_level, 1, "R7 trip");
    for (int i = 0; i < LAT; i++) drive(1, 0, 0);
    chk(stop_seen, 1, "R8 delayed stop");
    chk(in_ready, 0, "R8 ready low");
    for (int i = 0; i < HI - LO + 1; i++) drive(0, 0, 1);
    chk(off_level, 0, "R7 release");
    // R6 saturation at both ends
    for (int i = 0; i < DEPTH + 3; i++) drive(0, 1, 0);
    for (int i = 0; i < DEPTH + 3; i++) drive(0, 0, 1);
    chk(off_level, 0, "R6 floor");
    // stop/go random
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 100) < 60, ($urandom % 100) < 50, ($urandom % 100) < 45);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule